// File: doc/BRIEF.md
# Fuse Word Burn Sequencer

This block runs the serial burn of one fuse word. When the controller around it raises a start request while the block is idle, it captures the already-masked data word and a packed timing word. It then walks the data from the least significant bit upwards by shifting it right with zero fill. A bit that is 0 is passed over. A bit that is 1 gets a program strobe of a programmed length, with quiet relax intervals on either side. After the last bit comes a read-settle wait. Busy then falls, and a mandatory quiet gap keeps the next fuse operation from starting until it has elapsed.

All pulse lengths are clock-cycle counts taken from fields of the timing word. The post-write gap is a parameter in clock cycles, because it is fixed in time rather than tied to the fuse technology settings. The block has no address decoding and no lock checking. It sees only data that the controller has already qualified.

Top module: `fuse_burn_sequencer`

## Requirements
- R1: While reset is held and after it is released, busy, fuseStrobe and done are low and bitIndex is 0 until a start is accepted.
- R2: A start request sampled high at a clock edge while the block is idle is accepted. At that edge it captures burnData and timingCfg, and busy is high from the next cycle.
- R3: Bits are handled from bit 0 up to bit 31. Each bit begins with one evaluation cycle in which busy is high, fuseStrobe is low and bitIndex equals the bit position.
- R4: After its evaluation cycle, a bit of value 1 gets RELAX quiet cycles, then PROG cycles with fuseStrobe high, then RELAX quiet cycles, with bitIndex holding its position throughout. A bit of value 0 never raises fuseStrobe.
- R5: PROG is timingCfg[11:0], RELAX is timingCfg[15:12] and READ is timingCfg[21:16]. timingCfg[31:22] has no effect.
- R6: A PROG, RELAX or READ field that holds zero is used as a count of one.
- R7: After the last bit, busy stays high for READ settle cycles, with fuseStrobe low and bitIndex 0.
- R8: Busy then falls for a gap of GAP_CYCLES cycles. done is high only in the last gap cycle, and the cycle after it is idle.
- R9: A start request while busy is high or inside the gap, including the cycle in which done is high, is ignored.
- R10: Changing burnData or timingCfg after a start has been accepted has no effect on the burn in progress.
- R11: fuseStrobe is never high while busy is low, and done is never high while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to burn one word |
| burnData | input | 32 | Masked data word; each 1 bit is burned |
| timingCfg | input | 32 | Packed PROG, RELAX and READ counts |
| fuseStrobe | output | 1 | Program strobe to the fuse array |
| bitIndex | output | 5 | Bit position under the strobe or evaluation |
| busy | output | 1 | Burn or read-settle in progress |
| done | output | 1 | One-cycle pulse in the last gap cycle |

## Verification
The bench overrides GAP_CYCLES to 6, where the default corresponds to 2 us. With that value, gap entry, the done cycle and a start arriving just before or just after the gap boundary all fall within a few cycles of each other, and the run covers many back-to-back burns. The timing words used keep PROG and RELAX at single-digit counts, and one uses the all-zero word to exercise the clamp. Full-word burns with every bit set therefore stay short enough that the per-cycle reference model follows every strobe edge. The unused upper timing bits are driven high in several of these words.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_EVAL,
    S_PRE,
    S_PULSE,
    S_POST,
    S_SETTLE,
    S_GAP
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic shift;
  } dpCmd_t;

endpackage

// File: rtl/fuse_seq_dp.sv
module fuse_seq_dp
  import fuse_seq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PROG_W  = 12,
  parameter int RELAX_W = 4,
  parameter int READ_W  = 6,
  localparam int IDX_W  = $clog2(DATA_W),
  localparam int USED_W = PROG_W + RELAX_W + READ_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCmd_t             cmd,
  input  logic [DATA_W-1:0]  dataIn,
  input  logic [USED_W-1:0]  timingIn,
  output logic               curBit,
  output logic               lastBit,
  output logic [IDX_W-1:0]   bitIdx,
  output logic [PROG_W-1:0]  progLen,
  output logic [RELAX_W-1:0] relaxLen,
  output logic [READ_W-1:0]  readLen
);

  localparam int RELAX_LSB = PROG_W;
  localparam int READ_LSB  = PROG_W + RELAX_W;

  logic [DATA_W-1:0]  shiftReg;
  logic [PROG_W-1:0]  progField;
  logic [RELAX_W-1:0] relaxField;
  logic [READ_W-1:0]  readField;

  assign progField  = timingIn[PROG_W-1:0];
  assign relaxField = timingIn[RELAX_LSB +: RELAX_W];
  assign readField  = timingIn[READ_LSB +: READ_W];

  assign curBit  = shiftReg[0];
  assign lastBit = (bitIdx == IDX_W'(DATA_W - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitIdx   <= '0;
      progLen  <= PROG_W'(1);
      relaxLen <= RELAX_W'(1);
      readLen  <= READ_W'(1);
    end else if (cmd.load) begin
      shiftReg <= dataIn;
      bitIdx   <= '0;
      // zero counts are not usable, run them as one
      progLen  <= (progField  == '0) ? PROG_W'(1)  : progField;
      relaxLen <= (relaxField == '0) ? RELAX_W'(1) : relaxField;
      readLen  <= (readField  == '0) ? READ_W'(1)  : readField;
    end else if (cmd.shift) begin
      shiftReg <= {1'b0, shiftReg[DATA_W-1:1]};
      bitIdx   <= lastBit ? '0 : bitIdx + IDX_W'(1);
    end
  end

  a_r10_data_held: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.load && !cmd.shift) |=> $stable(shiftReg) && $stable(progLen));

  a_r3_index_steps: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.shift && !lastBit) |=> bitIdx == $past(bitIdx) + IDX_W'(1));

  a_r6_no_zero_len: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> (progLen != '0) && (relaxLen != '0) && (readLen != '0));

endmodule

// File: rtl/fuse_seq_ctrl.sv
module fuse_seq_ctrl
  import fuse_seq_pkg::*;
#(
  parameter int PROG_W     = 12,
  parameter int RELAX_W    = 4,
  parameter int READ_W     = 6,
  parameter int GAP_CYCLES = 250,
  parameter int CNT_W      = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic               curBit,
  input  logic               lastBit,
  input  logic [PROG_W-1:0]  progLen,
  input  logic [RELAX_W-1:0] relaxLen,
  input  logic [READ_W-1:0]  readLen,
  output dpCmd_t             cmd,
  output logic               busy,
  output logic               fuseStrobe,
  output logic               done
);

  seqState_t state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic cntZero;

  assign cntZero = (cnt == '0);

  always_comb begin
    stateNext = state;
    cntNext   = cntZero ? cnt : cnt - CNT_W'(1);
    cmd       = '0;
    unique case (state)
      S_IDLE: begin
        if (startReq) begin
          cmd.load  = 1'b1;
          stateNext = S_EVAL;
        end
      end
      S_EVAL: begin
        if (curBit) begin
          stateNext = S_PRE;
          cntNext   = CNT_W'(relaxLen) - CNT_W'(1);
        end else begin
          cmd.shift = 1'b1;
          if (lastBit) begin
            stateNext = S_SETTLE;
            cntNext   = CNT_W'(readLen) - CNT_W'(1);
          end
        end
      end
      S_PRE: begin
        if (cntZero) begin
          stateNext = S_PULSE;
          cntNext   = CNT_W'(progLen) - CNT_W'(1);
        end
      end
      S_PULSE: begin
        if (cntZero) begin
          stateNext = S_POST;
          cntNext   = CNT_W'(relaxLen) - CNT_W'(1);
        end
      end
      S_POST: begin
        if (cntZero) begin
          cmd.shift = 1'b1;
          if (lastBit) begin
            stateNext = S_SETTLE;
            cntNext   = CNT_W'(readLen) - CNT_W'(1);
          end else begin
            stateNext = S_EVAL;
          end
        end
      end
      S_SETTLE: begin
        if (cntZero) begin
          stateNext = S_GAP;
          cntNext   = CNT_W'(GAP_CYCLES - 1);
        end
      end
      S_GAP: begin
        if (cntZero) stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  assign busy       = (state != S_IDLE) && (state != S_GAP);
  assign fuseStrobe = (state == S_PULSE);
  assign done       = (state == S_GAP) && cntZero;

  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && startReq) |=> busy);

  a_r9_gap_blocks_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_GAP && startReq) |=> (state != S_EVAL));

  a_r11_strobe_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    fuseStrobe |-> busy);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);

  a_r4_index_under_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (fuseStrobe && $past(fuseStrobe)) |-> !$past(cmd.shift));

endmodule

// File: rtl/fuse_burn_sequencer.sv
module fuse_burn_sequencer
  import fuse_seq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int TIMING_W   = 32,
  parameter int PROG_W     = 12,
  parameter int RELAX_W    = 4,
  parameter int READ_W     = 6,
  parameter int GAP_CYCLES = 250,
  localparam int IDX_W     = $clog2(DATA_W),
  localparam int USED_W    = PROG_W + RELAX_W + READ_W,
  localparam int GAP_W     = $clog2(GAP_CYCLES + 1),
  localparam int LEN_W     = (PROG_W > READ_W) ? PROG_W : READ_W,
  localparam int CNT_W     = (LEN_W > GAP_W) ? LEN_W : GAP_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic [DATA_W-1:0]   burnData,
  input  logic [TIMING_W-1:0] timingCfg,
  output logic                fuseStrobe,
  output logic [IDX_W-1:0]    bitIndex,
  output logic                busy,
  output logic                done
);

  dpCmd_t             cmd;
  logic               curBit, lastBit;
  logic [PROG_W-1:0]  progLen;
  logic [RELAX_W-1:0] relaxLen;
  logic [READ_W-1:0]  readLen;

  logic unusedTimingHigh;
  assign unusedTimingHigh = ^timingCfg[TIMING_W-1:USED_W];

  fuse_seq_dp #(
    .DATA_W(DATA_W), .PROG_W(PROG_W), .RELAX_W(RELAX_W), .READ_W(READ_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .dataIn(burnData), .timingIn(timingCfg[USED_W-1:0]),
    .curBit(curBit), .lastBit(lastBit), .bitIdx(bitIndex),
    .progLen(progLen), .relaxLen(relaxLen), .readLen(readLen)
  );

  fuse_seq_ctrl #(
    .PROG_W(PROG_W), .RELAX_W(RELAX_W), .READ_W(READ_W),
    .GAP_CYCLES(GAP_CYCLES), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .curBit(curBit), .lastBit(lastBit),
    .progLen(progLen), .relaxLen(relaxLen), .readLen(readLen),
    .cmd(cmd), .busy(busy), .fuseStrobe(fuseStrobe), .done(done)
  );

  a_r11_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && !fuseStrobe);

endmodule

// File: tb/tb_fuse_burn_sequencer.sv
module tb_fuse_burn_sequencer;

  localparam int GAP = 6;
  localparam realtime HALF = 4ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [31:0] burnData = '0;
  logic [31:0] timingCfg = '0;
  logic        fuseStrobe, busy, done;
  logic [4:0]  bitIndex;

  int runCount = 0;
  int failCount = 0;
  int cycleNo = 0;
  string curReq = "R1";

  // expected per cycle: [7] busy [6] strobe [5] done [4:0] index
  logic [7:0] expQ[$];

  always #HALF clk = ~clk;

  fuse_burn_sequencer #(.GAP_CYCLES(GAP)) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .burnData(burnData),
    .timingCfg(timingCfg), .fuseStrobe(fuseStrobe), .bitIndex(bitIndex),
    .busy(busy), .done(done)
  );

  function automatic void pushBurn(logic [31:0] d, logic [31:0] t);
    int p = int'(t[11:0]);
    int r = int'(t[15:12]);
    int s = int'(t[21:16]);
    if (p == 0) p = 1;   // R6 clamp
    if (r == 0) r = 1;
    if (s == 0) s = 1;
    for (int i = 0; i < 32; i++) begin
      expQ.push_back({3'b100, 5'(i)});
      if (d[i]) begin
        for (int k = 0; k < r; k++) expQ.push_back({3'b100, 5'(i)});
        for (int k = 0; k < p; k++) expQ.push_back({3'b110, 5'(i)});
        for (int k = 0; k < r; k++) expQ.push_back({3'b100, 5'(i)});
      end
    end
    for (int k = 0; k < s; k++) expQ.push_back(8'h80);
    for (int g = 0; g < GAP; g++) expQ.push_back({2'b00, (g == GAP - 1), 5'd0});
  endfunction

  task automatic step(input logic s, input logic [31:0] d, input logic [31:0] t);
    logic [7:0] exp;
    logic [7:0] act;
    logic wasIdle;
    @(negedge clk);
    cycleNo++;
    if (expQ.size() > 0) begin
      exp = expQ.pop_front();
      wasIdle = 1'b0;
    end else begin
      exp = 8'h00;
      wasIdle = 1'b1;
    end
    act = {busy, fuseStrobe, done, bitIndex};
    runCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s cycle %0d: busy/strobe/done/idx actual %h expected %h",
               curReq, cycleNo, act, exp);
    end
    startReq  = s;
    burnData  = d;
    timingCfg = t;
    if (s && wasIdle && rstN) pushBurn(d, t);
  endtask

  task automatic drain();
    while (expQ.size() > 0) step(1'b0, 32'h0, 32'h0);
  endtask

  task automatic burn(input logic [31:0] d, input logic [31:0] t);
    step(1'b1, d, t);
    drain();
  endtask

  initial begin
    // R1: reset state, held and released
    curReq = "R1";
    repeat (3) step(1'b0, 32'h0, 32'h0);
    rstN = 1'b1;
    repeat (3) step(1'b0, 32'h0, 32'h0);

    // R3 R7 R8: all-zero word, every bit skipped
    curReq = "R3";
    burn(32'h0000_0000, 32'h0003_2005);

    // R4 R5: ends of the word burned, upper timing bits set (ignored)
    curReq = "R4";
    burn(32'h8000_0001, 32'hFFC3_2005);

    // R4: every bit burned with minimum counts
    curReq = "R4";
    burn(32'hFFFF_FFFF, 32'h0001_1001);

    // R6: all fields zero behave as one
    curReq = "R6";
    burn(32'h0000_0005, 32'h0000_0000);

    // R5: distinct field values on a mixed pattern
    curReq = "R5";
    burn(32'h1248_8421, 32'h0004_3007);

    // R9 R10: start held high and inputs changing every cycle during burn and gap
    curReq = "R9";
    step(1'b1, 32'h0000_0300, 32'h0002_2003);
    while (expQ.size() > 0) step(1'b1, $urandom, $urandom);
    curReq = "R10";
    step(1'b0, 32'h0, 32'h0);

    // R2 R8: back-to-back start on the first idle cycle after done
    curReq = "R2";
    step(1'b1, 32'h4000_0000, 32'h0001_1002);
    drain();
    step(1'b1, 32'h0000_0002, 32'h0002_1001);
    drain();

    // R7: long settle
    curReq = "R7";
    burn(32'h0000_0010, 32'h0009_1001);

    repeat (4) step(1'b0, 32'h0, 32'h0);
    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end

  initial begin
    #(HALF * 2 * 150000);
    failCount++;
    $display("FAIL watchdog expired during %s", curReq);
    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end

endmodule